// File: doc/BRIEF.md
# Page-Policy DRAM Command Sequencer

This block sits between a request source and a DRAM timing checker. Each request names a bank, a row, a column and a direction. The block turns it into the short run of DRAM commands that the request needs. It keeps one open-row record per bank, so it knows whether the target bank is idle, already has the wanted row open, or has some other row open. From that it emits an activate, a precharge, or a column command as required.

A policy input picks the page mode. With the open policy, a row stays open after an access, so a later access to the same row costs a single column command. With the closed policy, the column command is the compound form that also precharges the bank. A closed-policy access to an idle bank therefore takes two commands instead of three, and it leaves the bank idle again.

Commands leave through a valid/ready handshake. The timing checker downstream stalls each command until it is legal. The block works on one request at a time. It raises its request-ready again only after the current request's column command has gone out.

Top module: `page_cmd_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` is 0, `cmd_op` is 0 (no command), and every bank is treated as idle.
- R2: `cmd_op` codes are 1 precharge, 2 activate, 3 read, 4 write, 5 read with precharge, 6 write with precharge. A request to an idle bank produces an activate carrying the request's row, then its column command carrying the request's column. Every command carries the request's bank.
- R3: With the open policy (`closed_page`=0), a request to the row already open in its bank produces only a plain read (3) or write (4).
- R4: With the open policy, a request to a bank that has a different row open produces precharge, activate, then a plain column command.
- R5: With the closed policy (`closed_page`=1), the column command is the compound form (5 or 6), and the bank is idle afterwards. A repeat access to the same row therefore again needs an activate followed by a compound column command.
- R6: With the closed policy, a request that hits a row left open by an earlier open-policy access needs only a compound column command. A request that misses such a row needs precharge, activate, then a compound column command.
- R7: While `cmd_valid` is 1 and `cmd_ready` is 0, the command and its fields stay unchanged. The sequence advances only when a command is taken.
- R8: `req_ready` is 0 from the cycle after a request is accepted until the cycle after its column command is taken, and a request offered in that window is not accepted.
- R9: The policy is sampled when the request is accepted. A change of `closed_page` while the request is in progress does not alter its commands.
- R10: Each bank keeps its own open row. Opening or closing a row in one bank does not change the command sequence that another bank needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| closed_page | input | 1 | Page policy: 0 keeps rows open, 1 closes after each access |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_bank | input | BANK_W | Request bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| req_write | input | 1 | 1 for write, 0 for read |
| cmd_valid | output | 1 | Command offered downstream |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_op | output | 3 | Command code (see R2) |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Row, meaningful with activate |
| cmd_col | output | COL_W | Column, meaningful with column commands |

## Verification
The bench drives each of the three bank states a request can meet: idle, same row open, and a different row open. It does this under both policies, so every one of the six command sequences is produced at least once, and each one is checked for its full command order and fields. Reads and writes alternate across the scenarios, which separates the plain codes from the compound codes. Back-to-back accesses to one row under the closed policy show that the compound command really left the bank idle. Accesses that interleave two banks on the same row number show that the open-row records are kept per bank. One scenario stalls the downstream ready for several cycles, and another flips the policy in the middle of a request, to check command holding and policy sampling.

// File: rtl/psq_pkg.sv
package psq_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_PRE = 3'd1,
        OP_ACT = 3'd2,
        OP_RD  = 3'd3,
        OP_WR  = 3'd4,
        OP_RDA = 3'd5,
        OP_WRA = 3'd6
    } psq_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_ACT  = 2'd2,
        ST_COL  = 2'd3
    } psq_st_e;

    // Column command chosen by direction and whether the bank closes after it
    function automatic psq_op_e col_op(input logic wr, input logic autopre);
        if (autopre) return wr ? OP_WRA : OP_RDA;
        return wr ? OP_WR : OP_RD;
    endfunction

    // First step of a request from the state of its bank
    function automatic psq_st_e entry_step(input logic bank_open, input logic row_hit);
        if (bank_open && row_hit) return ST_COL;
        if (bank_open)            return ST_PRE;
        return ST_ACT;
    endfunction

    function automatic logic is_col(input psq_op_e op);
        return (op == OP_RD) || (op == OP_WR) || (op == OP_RDA) || (op == OP_WRA);
    endfunction

    function automatic logic is_autopre(input psq_op_e op);
        return (op == OP_RDA) || (op == OP_WRA);
    endfunction

endpackage

// File: rtl/psq_row_table.sv
module psq_row_table #(
    parameter int BANKS = 4,
    parameter int ROW_W = 14,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] rd_bank,
    output logic              rd_open,
    output logic [ROW_W-1:0]  rd_row,
    input  logic [BANK_W-1:0] chk_bank,
    output logic              chk_open,
    output logic [ROW_W-1:0]  chk_row,
    input  logic              set_en,
    input  logic [BANK_W-1:0] set_bank,
    input  logic [ROW_W-1:0]  set_row,
    input  logic              clr_en,
    input  logic [BANK_W-1:0] clr_bank
);

    logic [BANKS-1:0]            open_vec;
    logic [BANKS-1:0][ROW_W-1:0] row_vec;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic             open_r;
        logic [ROW_W-1:0] row_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                open_r <= 1'b0;
                row_r  <= '0;
            end else if (set_en && set_bank == BANK_W'(b)) begin
                open_r <= 1'b1;
                row_r  <= set_row;
            end else if (clr_en && clr_bank == BANK_W'(b)) begin
                open_r <= 1'b0;
            end
        end

        assign open_vec[b] = open_r;
        assign row_vec[b]  = row_r;
    end

    assign rd_open  = open_vec[rd_bank];
    assign rd_row   = row_vec[rd_bank];
    assign chk_open = open_vec[chk_bank];
    assign chk_row  = row_vec[chk_bank];

    AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(set_en && clr_en && set_bank == clr_bank)); // R2

endmodule

// File: rtl/psq_ctrl.sv
module psq_ctrl
    import psq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              closed_page,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_write,
    input  logic              bank_open,
    input  logic [ROW_W-1:0]  bank_row,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output psq_op_e           cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              set_en,
    output logic              clr_en
);

    psq_st_e           st_q, st_d;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              wr_q;
    logic              closed_q;
    logic              accept;
    logic              fire;

    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign cmd_valid = (st_q != ST_IDLE);
    assign fire      = cmd_valid && cmd_ready;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (accept) st_d = entry_step(bank_open, bank_row == req_row);
            ST_PRE:  if (fire)   st_d = ST_ACT;
            ST_ACT:  if (fire)   st_d = ST_COL;
            ST_COL:  if (fire)   st_d = ST_IDLE;
            default:             st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            bank_q   <= '0;
            row_q    <= '0;
            col_q    <= '0;
            wr_q     <= 1'b0;
            closed_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                bank_q   <= req_bank;
                row_q    <= req_row;
                col_q    <= req_col;
                wr_q     <= req_write;
                closed_q <= closed_page;
            end
        end
    end

    always_comb begin
        unique case (st_q)
            ST_PRE:  cmd_op = OP_PRE;
            ST_ACT:  cmd_op = OP_ACT;
            ST_COL:  cmd_op = col_op(wr_q, closed_q);
            default: cmd_op = OP_NOP;
        endcase
    end

    assign cmd_bank = bank_q;
    assign cmd_row  = row_q;
    assign cmd_col  = col_q;
    assign set_en   = fire && (st_q == ST_ACT);
    assign clr_en   = fire && ((st_q == ST_PRE) || (st_q == ST_COL && closed_q));

    AST_HOLD_CMD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_bank)
                                       && $stable(cmd_row) && $stable(cmd_col))); // R7
    AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !req_ready); // R8
    AST_COL_FREES_REQ: assert property (@(posedge clk) disable iff (rst)
        (fire && is_col(cmd_op)) |=> req_ready); // R8
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
        accept |=> cmd_valid); // R8
    AST_POLICY_KEPT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && $past(cmd_valid)) |-> $stable(closed_q)); // R9

endmodule

// File: rtl/page_cmd_seq.sv
module page_cmd_seq
    import psq_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int ROW_W = 14,
    parameter int COL_W = 10,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              closed_page,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_write,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [2:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col
);

    logic             look_open, chk_open;
    logic [ROW_W-1:0] look_row, chk_row;
    logic             set_en, clr_en;
    psq_op_e          op_w;

    psq_row_table #(.BANKS(BANKS), .ROW_W(ROW_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_bank  (req_bank),
        .rd_open  (look_open),
        .rd_row   (look_row),
        .chk_bank (cmd_bank),
        .chk_open (chk_open),
        .chk_row  (chk_row),
        .set_en   (set_en),
        .set_bank (cmd_bank),
        .set_row  (cmd_row),
        .clr_en   (clr_en),
        .clr_bank (cmd_bank)
    );

    psq_ctrl #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .closed_page (closed_page),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_bank    (req_bank),
        .req_row     (req_row),
        .req_col     (req_col),
        .req_write   (req_write),
        .bank_open   (look_open),
        .bank_row    (look_row),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_op      (op_w),
        .cmd_bank    (cmd_bank),
        .cmd_row     (cmd_row),
        .cmd_col     (cmd_col),
        .set_en      (set_en),
        .clr_en      (clr_en)
    );

    assign cmd_op = op_w;

    AST_ACT_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && op_w == OP_ACT) |-> !chk_open); // R2
    AST_PRE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && op_w == OP_PRE) |-> chk_open); // R4
    AST_COL_ON_OPEN_ROW: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && is_col(op_w)) |-> (chk_open && chk_row == cmd_row)); // R3
    AST_AUTOPRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && is_autopre(op_w)) |=> !chk_open); // R5
    AST_IDLE_NO_OP: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> (op_w == OP_NOP)); // R1

endmodule

// File: tb/tb_page_cmd_seq.sv
module tb_page_cmd_seq;

    localparam int BANKS  = 4;
    localparam int ROW_W  = 14;
    localparam int COL_W  = 10;
    localparam int BANK_W = 2;

    logic              clk = 1'b0;
    logic              rst;
    logic              closed_page;
    logic              req_valid;
    logic              req_ready;
    logic [BANK_W-1:0] req_bank;
    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;
    logic              req_write;
    logic              cmd_valid;
    logic              cmd_ready;
    logic [2:0]        cmd_op;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0]  cmd_row;
    logic [COL_W-1:0]  cmd_col;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    page_cmd_seq #(.BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W)) dut (
        .clk(clk), .rst(rst), .closed_page(closed_page),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .req_write(req_write),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Issue one request and collect its commands; ops lists expected codes
    task automatic run_req(input string req, input int bank, input int row, input int col,
                           input bit wr, input bit pol, input int n,
                           input int e0, input int e1, input int e2,
                           input int stall, input bit flip_pol);
        int exp_ops[3];
        int got  = 0;
        int hold = 0;
        int hold_op = 0;
        int hold_col = 0;
        bit done = 1'b0;
        exp_ops[0] = e0; exp_ops[1] = e1; exp_ops[2] = e2;
        @(negedge clk);
        check(req_ready == 1'b1, "R8", "req_ready idle", int'(req_ready), 1);
        req_valid   = 1'b1;
        req_bank    = BANK_W'(bank);
        req_row     = ROW_W'(row);
        req_col     = COL_W'(col);
        req_write   = wr;
        closed_page = pol;
        cmd_ready   = (stall == 0);
        @(negedge clk);
        req_bank = BANK_W'((bank + 1) % BANKS);
        req_row  = ROW_W'(row + 7);
        if (flip_pol) closed_page = ~pol;
        for (int cyc = 0; cyc < 40 && !done; cyc++) begin
            if (cmd_valid) begin
                check(req_ready == 1'b0, "R8", "req_ready busy", int'(req_ready), 0);
                if (hold < stall) begin
                    if (hold == 0) begin
                        hold_op  = int'(cmd_op);
                        hold_col = int'(cmd_col);
                    end else begin
                        check(int'(cmd_op) == hold_op && int'(cmd_col) == hold_col,
                              "R7", "op held", int'(cmd_op), hold_op);
                    end
                    hold++;
                    cmd_ready = 1'b0;
                end else begin
                    cmd_ready = 1'b1;
                    hold = 0;
                    if (got < n)
                        check(int'(cmd_op) == exp_ops[got], req, "op", int'(cmd_op), exp_ops[got]);
                    else
                        check(1'b0, req, "extra command", int'(cmd_op), 0);
                    check(int'(cmd_bank) == bank, "R2", "bank", int'(cmd_bank), bank);
                    if (cmd_op == 3'd2)
                        check(int'(cmd_row) == row, "R2", "row", int'(cmd_row), row);
                    if (cmd_op >= 3'd3) begin
                        check(int'(cmd_col) == col, "R2", "col", int'(cmd_col), col);
                        done = 1'b1;
                    end
                    got++;
                end
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(got == n, req, "command count", got, n);
        check(cmd_valid == 1'b0 && req_ready == 1'b1, "R8", "idle after column",
              int'(req_ready), 1);
        cmd_ready = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
        check(cmd_valid == 1'b0, "R1", "cmd_valid", int'(cmd_valid), 0);
        check(cmd_op == 3'd0, "R1", "cmd_op", int'(cmd_op), 0);
    endtask

    task automatic t_open_page();
        run_req("R1", 0, 5, 17, 1'b0, 1'b0, 2, 2, 3, 0, 0, 1'b0);   // idle bank after reset
        run_req("R3", 0, 5, 18, 1'b1, 1'b0, 1, 4, 0, 0, 0, 1'b0);   // hit, write
        run_req("R4", 0, 9, 19, 1'b0, 1'b0, 3, 1, 2, 3, 0, 1'b0);   // miss
    endtask

    task automatic t_stall();
        run_req("R7", 3, 40, 33, 1'b1, 1'b0, 2, 2, 4, 0, 3, 1'b0);
        run_req("R7", 3, 41, 34, 1'b0, 1'b0, 3, 1, 2, 3, 2, 1'b0);
    endtask

    task automatic t_banks();
        run_req("R10", 1, 9, 20, 1'b0, 1'b0, 2, 2, 3, 0, 0, 1'b0);  // bank0 row9 open, bank1 idle
        run_req("R10", 0, 9, 21, 1'b1, 1'b0, 1, 4, 0, 0, 0, 1'b0);  // bank0 still open on row9
    endtask

    task automatic t_closed_page();
        run_req("R5", 2, 3, 22, 1'b0, 1'b1, 2, 2, 5, 0, 0, 1'b0);
        run_req("R5", 2, 3, 23, 1'b1, 1'b1, 2, 2, 6, 0, 0, 1'b0);   // bank closed again
        run_req("R6", 0, 9, 24, 1'b0, 1'b1, 1, 5, 0, 0, 0, 1'b0);   // hit on row left open
        run_req("R6", 0, 9, 25, 1'b0, 1'b0, 2, 2, 3, 0, 0, 1'b0);   // compound closed it
        run_req("R6", 1, 7, 26, 1'b1, 1'b1, 3, 1, 2, 6, 0, 1'b0);   // miss on open bank1
    endtask

    task automatic t_policy_sample();
        run_req("R9", 2, 1, 27, 1'b0, 1'b0, 2, 2, 3, 0, 0, 1'b1);   // flip to closed mid-way
        run_req("R9", 2, 1, 28, 1'b1, 1'b1, 1, 6, 0, 0, 0, 1'b1);   // row stayed open; flip to open
        run_req("R9", 2, 1, 29, 1'b0, 1'b0, 2, 2, 3, 0, 0, 1'b0);   // compound closed it
    endtask

    initial begin
        rst = 1'b1; closed_page = 1'b0; req_valid = 1'b0; req_bank = '0;
        req_row = '0; req_col = '0; req_write = 1'b0; cmd_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_open_page();
        t_stall();
        t_banks();
        t_closed_page();
        t_policy_sample();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule